// File: doc/BRIEF.md
# Programmable Three-Channel Colour Matrix Converter

This block turns each incoming pixel of three 12-bit unsigned channels into three new channels. Each output channel is a weighted sum of all three inputs plus a constant, so one matrix can move video between colour spaces, for example from high-definition luma/chroma to red/green/blue. The nine weights and three constants are 13-bit signed words. They are loaded one byte at a time through a small write port and share one fixed-point scale that can be chosen at run time.

Pixels enter with a valid strobe and leave exactly three clock cycles later with a matching strobe. Results are rounded to the nearest code and clamped to 0..4095. When the converter is disabled, each input channel is copied to the output channel of the same number with the same three-cycle delay, so downstream timing does not shift when conversion is turned on or off.

Top module: `csc_top`

## Requirements
- R1: Output channel k (k = 0, 1, 2) is Wk0·in0 + Wk1·in1 + Wk2·in2 + Ok. Coefficient index 4k+j holds Wkj for j = 0..2, and index 4k+3 holds the constant Ok.
- R2: Coefficient index n (0..11) is written through two addresses. Address 2n takes the upper 5 bits of the 13-bit two's-complement word from data bits 4:0. Address 2n+1 takes the lower 8 bits from data bits 7:0. Address 24 is control: bit 0 enables conversion and bits 2:1 select the scale.
- R3: Scale code 0 makes 4096 weight codes equal to 1.0, code 1 makes 2048 codes equal to 1.0, and codes 2 and 3 make 1024 codes equal to 1.0. Sums are rounded to nearest, with ties going upward.
- R4: The constants follow the same scale. A constant of c adds c output codes under scale 0, 2c under scale 1 and 4c under scales 2 and 3.
- R5: Writing the upper part changes no coefficient. The staged upper part and a new lower byte take effect together when the lower byte is written.
- R6: A converted result below 0 gives 0, and a result above 4095 gives 4095.
- R7: pix_vld_o repeats pix_vld_i exactly three cycles later. Output data belongs to the pixel that carried that strobe.
- R8: With the enable bit clear, output channel k equals input channel k of the pixel three cycles earlier.
- R9: After reset, conversion is disabled, the scale is 1, coefficient 0 is 0x0C52 and coefficient 1 is 0x0800. All outputs are zero.
- R10: Writes to addresses 25 to 31 change neither the coefficients, nor the scale, nor the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 8 | Register write data |
| pix_vld_i | input | 1 | Input pixel valid |
| pix_c0_i | input | 12 | Input channel 0 |
| pix_c1_i | input | 12 | Input channel 1 |
| pix_c2_i | input | 12 | Input channel 2 |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_c0_o | output | 12 | Output channel 0 |
| pix_c1_o | output | 12 | Output channel 1 |
| pix_c2_o | output | 12 | Output channel 2 |

## Verification
Every scale code is run with random signed weights and random pixel streams. A design that shifts by the wrong amount, or that leaves the constants unscaled, gives results off by a factor of two or four. Tests drive the sum well past both limits, so a clamp that wraps around shows large wrong values where 0 or 4095 are expected. A write of only the upper part must leave results unchanged, which exposes a design that commits half-written coefficients. Bypass and strobe timing are checked cycle by cycle, so a path one register short or long is reported.

// File: rtl/csc_pkg.sv
// Shared constants, types and helpers of the colour matrix converter.
// Assumes two's-complement coefficients and unsigned pixel channels.
package csc_pkg;
    parameter int PIX_W    = 12;
    parameter int COEF_W   = 13;
    parameter int N_CH     = 3;
    parameter int ADDR_W   = 5;
    parameter int FRAC_MAX = 12;
    localparam int LO_W      = 8;
    localparam int HI_W      = COEF_W - LO_W;
    localparam int N_COEF    = N_CH * (N_CH + 1);
    localparam int CTRL_ADDR = 2 * N_COEF;
    localparam int PROD_W    = COEF_W + PIX_W + 1;
    localparam int ACC_W     = PROD_W + 2;
    localparam int PIX_MAX   = (1 << PIX_W) - 1;

    typedef logic [1:0] scale_t;

    // Right-shift amount for a scale code: 12, 11, 10, 10.
    function automatic int shift_of(scale_t m);
        return FRAC_MAX - (m[1] ? 2 : int'(m[0]));
    endfunction

    // Reset coefficient table (HD luma/chroma to RGB at scale 1).
    function automatic logic [COEF_W-1:0] reset_coef(int n);
        case (n)
            0:  return 13'h0C52;
            1:  return 13'h0800;
            2:  return 13'h0000;
            3:  return -13'sd1577;
            4:  return -13'sd937;
            5:  return 13'h0800;
            6:  return -13'sd375;
            7:  return 13'sd656;
            8:  return 13'h0000;
            9:  return 13'h0800;
            10: return 13'sd3711;
            default: return -13'sd1856;
        endcase
    endfunction
endpackage

// File: rtl/csc_coef_regs.sv
// Coefficient and control register bank.
// Assumes one byte write per cycle. The upper part of a coefficient is
// staged in one shared register and only merged on the lower-byte write.
module csc_coef_regs
    import csc_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [7:0]                        wdata,
    output logic [N_COEF-1:0][COEF_W-1:0]     coef_o,
    output scale_t                            scale_o,
    output logic                              en_o
);
    logic [HI_W-1:0]                  hi_stage_q;
    logic [N_COEF-1:0][COEF_W-1:0]    coef_q;
    scale_t                           scale_q;
    logic                             en_q;
    int                               idx;

    // Coefficient slot addressed by the current write.
    always_comb idx = int'(addr) >> 1;

    // Register updates: stage upper part, commit on lower byte, control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_stage_q <= '0;
            for (int n = 0; n < N_COEF; n++) coef_q[n] <= reset_coef(n);
            scale_q    <= 2'b01;
            en_q       <= 1'b0;
        end else if (we) begin
            if (int'(addr) < CTRL_ADDR) begin
                if (!addr[0]) hi_stage_q <= wdata[HI_W-1:0];
                else          coef_q[idx] <= {hi_stage_q, wdata};
            end else if (int'(addr) == CTRL_ADDR) begin
                en_q    <= wdata[0];
                scale_q <= wdata[2:1];
            end
        end
    end

    assign coef_o  = coef_q;
    assign scale_o = scale_q;
    assign en_o    = en_q;

    // R5
    hi_write_holds_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !addr[0] && int'(addr) < CTRL_ADDR) |=> $stable(coef_q));

    // R10
    unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(addr) > CTRL_ADDR) |=> ($stable(coef_q) && $stable(scale_q) && $stable(en_q)));
endmodule

// File: rtl/csc_lane.sv
// One output channel of the converter: multiply, sum with offset and
// rounding, then shift and clamp. Three register stages.
// Assumes the top supplies the scale and bypass flags aligned to stages.
module csc_lane
    import csc_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_CH-1:0][COEF_W-1:0]    wt_i,
    input  logic [COEF_W-1:0]              off_i,
    input  logic [N_CH-1:0][PIX_W-1:0]     pix_i,
    input  logic [PIX_W-1:0]               pass_i,
    input  scale_t                         scale_s1_i,
    input  scale_t                         scale_s2_i,
    input  logic                           byp_s2_i,
    output logic [PIX_W-1:0]               res_o
);
    logic signed [PROD_W-1:0]    prod_q [N_CH];
    logic signed [ACC_W-1:0]     acc_q;
    logic signed [ACC_W-1:0]     acc_d;
    logic signed [ACC_W-1:0]     shifted;
    logic [PIX_W-1:0]            pass_s1_q, pass_s2_q, res_q;
    int                          sh_s1, sh_s2;

    // Stage 1: full-precision products of weight and unsigned pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < N_CH; j++) prod_q[j] <= '0;
            pass_s1_q <= '0;
        end else begin
            for (int j = 0; j < N_CH; j++)
                prod_q[j] <= $signed(wt_i[j]) * $signed({1'b0, pix_i[j]});
            pass_s1_q <= pass_i;
        end
    end

    // Sum of products, offset aligned to full scale, and rounding half.
    always_comb begin
        sh_s1 = shift_of(scale_s1_i);
        acc_d = ACC_W'($signed(off_i)) <<< FRAC_MAX;
        for (int j = 0; j < N_CH; j++) acc_d = acc_d + ACC_W'(prod_q[j]);
        acc_d = acc_d + (ACC_W'(1) <<< (sh_s1 - 1));
    end

    // Stage 2: hold the rounded sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            pass_s2_q <= '0;
        end else begin
            acc_q     <= acc_d;
            pass_s2_q <= pass_s1_q;
        end
    end

    // Scale-dependent shift of the rounded sum.
    always_comb begin
        sh_s2   = shift_of(scale_s2_i);
        shifted = acc_q >>> sh_s2;
    end

    // Stage 3: clamp or pass through.
    always_ff @(posedge clk) begin
        if (!rst_n)                  res_q <= '0;
        else if (byp_s2_i)           res_q <= pass_s2_q;
        else if (shifted < 0)        res_q <= '0;
        else if (shifted > PIX_MAX)  res_q <= PIX_W'(PIX_MAX);
        else                         res_q <= shifted[PIX_W-1:0];
    end

    assign res_o = res_q;

    // R6
    neg_sum_clamps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_s2_i && acc_q < 0) |=> (res_q == '0));

    // R6
    big_sum_clamps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_s2_i && acc_q >= (ACC_W'(1) <<< (PIX_W + FRAC_MAX))) |=> (res_q == PIX_W'(PIX_MAX)));
endmodule

// File: rtl/csc_top.sv
// Programmable three-channel colour matrix converter, top level.
// Assumes configuration is held steady while pixels are in flight.
// Latency is three cycles in both convert and bypass modes.
module csc_top
    import csc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [4:0]          cfg_addr,
    input  logic [7:0]          cfg_wdata,
    input  logic                pix_vld_i,
    input  logic [11:0]         pix_c0_i,
    input  logic [11:0]         pix_c1_i,
    input  logic [11:0]         pix_c2_i,
    output logic                pix_vld_o,
    output logic [11:0]         pix_c0_o,
    output logic [11:0]         pix_c1_o,
    output logic [11:0]         pix_c2_o
);
    logic [N_COEF-1:0][COEF_W-1:0]  coef;
    scale_t                         scale_cur, scale_s1, scale_s2;
    logic                           en_cur, en_s1, en_s2;
    logic                           vld_s1, vld_s2, vld_s3;
    logic [N_CH-1:0][PIX_W-1:0]     pix_in;
    logic [N_CH-1:0][PIX_W-1:0]     pix_out;
    logic [1:0]                     chk_age;

    assign pix_in = {pix_c2_i, pix_c1_i, pix_c0_i};

    csc_coef_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .coef_o  (coef),
        .scale_o (scale_cur),
        .en_o    (en_cur)
    );

    // Control pipeline: valid, enable and scale travel with the pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {vld_s1, vld_s2, vld_s3} <= '0;
            {en_s1, en_s2}           <= '0;
            scale_s1                 <= '0;
            scale_s2                 <= '0;
        end else begin
            vld_s1   <= pix_vld_i;
            vld_s2   <= vld_s1;
            vld_s3   <= vld_s2;
            en_s1    <= en_cur;
            en_s2    <= en_s1;
            scale_s1 <= scale_cur;
            scale_s2 <= scale_s1;
        end
    end

    for (genvar k = 0; k < N_CH; k++) begin : g_lane
        csc_lane u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .wt_i       (coef[4*k+2 -: 3]),
            .off_i      (coef[4*k+3]),
            .pix_i      (pix_in),
            .pass_i     (pix_in[k]),
            .scale_s1_i (scale_s1),
            .scale_s2_i (scale_s2),
            .byp_s2_i   (!en_s2),
            .res_o      (pix_out[k])
        );
    end

    assign pix_vld_o = vld_s3;
    assign pix_c0_o  = pix_out[0];
    assign pix_c1_o  = pix_out[1];
    assign pix_c2_o  = pix_out[2];

    // Cycles since reset, saturating, so the checks look back only that far.
    always_ff @(posedge clk) begin
        if (!rst_n)               chk_age <= '0;
        else if (chk_age != 2'd3) chk_age <= chk_age + 2'd1;
    end

    // R7
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_age == 2'd3) |-> (pix_vld_o == $past(pix_vld_i, 3)));

    // R8
    bypass_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_age == 2'd3 && !$past(en_cur, 3)) |->
        (pix_c0_o == $past(pix_c0_i, 3) && pix_c2_o == $past(pix_c2_i, 3)));
endmodule

// File: tb/csc_top_tb.sv
module csc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        pix_vld_i = 1'b0;
    logic [11:0] pix_c0_i = '0, pix_c1_i = '0, pix_c2_i = '0;
    logic        pix_vld_o;
    logic [11:0] pix_c0_o, pix_c1_o, pix_c2_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int mc [12];
    int mscale = 1;

    csc_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_vld_i(pix_vld_i), .pix_c0_i(pix_c0_i),
        .pix_c1_i(pix_c1_i), .pix_c2_i(pix_c2_i), .pix_vld_o(pix_vld_o),
        .pix_c0_o(pix_c0_o), .pix_c1_o(pix_c1_o), .pix_c2_o(pix_c2_o)
    );

    always #10 clk = ~clk;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model(int k, int x0, int x1, int x2);
        longint acc;
        int sh;
        acc = longint'(mc[4*k]) * x0 + longint'(mc[4*k+1]) * x1 +
              longint'(mc[4*k+2]) * x2 + (longint'(mc[4*k+3]) <<< 12);
        sh  = 12 - ((mscale >= 2) ? 2 : mscale);
        acc = (acc + (longint'(1) <<< (sh - 1))) >>> sh;
        if (acc < 0) return 0;
        if (acc > 4095) return 4095;
        return int'(acc);
    endfunction

    function automatic int out_ch(int k);
        return (k == 0) ? int'(pix_c0_o) : (k == 1) ? int'(pix_c1_o) : int'(pix_c2_o);
    endfunction

    task automatic wr(int a, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_coef(int n, int v);
        wr(2*n, (v >> 8) & 8'h1F);
        wr(2*n + 1, v & 8'hFF);
        mc[n] = v;
    endtask

    task automatic set_ctl(bit en, int sc);
        wr(24, (sc << 1) | int'(en));
        mscale = sc;
    endtask

    // Send one pixel and return its outputs, checking the strobe timing (R7).
    task automatic one_pixel(int x0, int x1, int x2, output int r0, output int r1, output int r2);
        @(negedge clk);
        pix_vld_i = 1'b1; pix_c0_i = 12'(x0); pix_c1_i = 12'(x1); pix_c2_i = 12'(x2);
        @(negedge clk);
        pix_vld_i = 1'b0;
        check("R7 valid low one cycle after", int'(pix_vld_o), 0);
        @(negedge clk);
        check("R7 valid low two cycles after", int'(pix_vld_o), 0);
        @(negedge clk);
        check("R7 valid high three cycles after", int'(pix_vld_o), 1);
        r0 = int'(pix_c0_o); r1 = int'(pix_c1_o); r2 = int'(pix_c2_o);
        @(negedge clk);
        check("R7 valid back low", int'(pix_vld_o), 0);
    endtask

    // Back-to-back random pixels, every lane against the model.
    task automatic run_stream(string tag, int n);
        int e [3][40];
        for (int i = 0; i < n + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                check({tag, " valid"}, int'(pix_vld_o), 1);
                for (int k = 0; k < 3; k++) check(tag, out_ch(k), e[k][i-3]);
            end
            if (i < n) begin
                int x0, x1, x2;
                x0 = int'($urandom_range(0, 4095));
                x1 = int'($urandom_range(0, 4095));
                x2 = int'($urandom_range(0, 4095));
                pix_vld_i = 1'b1; pix_c0_i = 12'(x0); pix_c1_i = 12'(x1); pix_c2_i = 12'(x2);
                for (int k = 0; k < 3; k++) e[k][i] = model(k, x0, x1, x2);
            end else pix_vld_i = 1'b0;
        end
    endtask

    task automatic t_reset();
        check("R9 valid at reset", int'(pix_vld_o), 0);
        check("R9 ch0 at reset", int'(pix_c0_o), 0);
        check("R9 ch1 at reset", int'(pix_c1_o), 0);
        check("R9 ch2 at reset", int'(pix_c2_o), 0);
    endtask

    task automatic t_bypass();
        int r0, r1, r2;
        one_pixel(123, 4095, 7, r0, r1, r2);
        check("R8 bypass ch0", r0, 123);
        check("R8 bypass ch1", r1, 4095);
        check("R8 bypass ch2", r2, 7);
    endtask

    task automatic t_defaults();
        int r0, r1, r2;
        wr(24, 8'h03);
        mscale = 1;
        wr_coef(2, 0);
        wr_coef(3, 0);
        one_pixel(100, 0, 0, r0, r1, r2);
        check("R9 reset A-weight 0x0C52 at scale 1", r0, 154);
        one_pixel(0, 100, 0, r0, r1, r2);
        check("R9 reset A-weight 0x0800 at scale 1", r0, 100);
    endtask

    task automatic t_modes();
        for (int sc = 0; sc < 4; sc++) begin
            set_ctl(1'b1, sc);
            for (int n = 0; n < 12; n++) begin
                int v;
                v = int'($urandom_range(0, 8191));
                if (v > 4095) v = v - 8192;
                wr_coef(n, v);
            end
            run_stream($sformatf("R1 R2 R3 random matrix scale %0d", sc), 16);
        end
    endtask

    task automatic t_offset();
        int r0, r1, r2;
        for (int n = 0; n < 12; n++) wr_coef(n, 0);
        wr_coef(3, 500);
        wr_coef(7, 1000);
        for (int sc = 0; sc < 4; sc++) begin
            set_ctl(1'b1, sc);
            one_pixel(4095, 4095, 4095, r0, r1, r2);
            check($sformatf("R4 offset ch0 scale %0d", sc), r0, (sc == 0) ? 500 : (sc == 1) ? 1000 : 2000);
            check($sformatf("R4 offset ch1 scale %0d", sc), r1, (sc == 0) ? 1000 : (sc == 1) ? 2000 : 4000);
        end
    endtask

    task automatic t_staging();
        int r0, r1, r2;
        set_ctl(1'b1, 0);
        for (int n = 0; n < 12; n++) wr_coef(n, 0);
        wr_coef(0, 16'h0400);
        one_pixel(400, 0, 0, r0, r1, r2);
        check("R5 before update", r0, 100);
        wr(0, 8'h08);
        one_pixel(400, 0, 0, r0, r1, r2);
        check("R5 upper part alone has no effect", r0, 100);
        wr(1, 8'h00);
        one_pixel(400, 0, 0, r0, r1, r2);
        check("R5 lower byte commits staged value", r0, 200);
    endtask

    task automatic t_saturate();
        int r0, r1, r2;
        set_ctl(1'b1, 2);
        for (int n = 0; n < 12; n++) wr_coef(n, 0);
        wr_coef(0, 4095);
        wr_coef(4, -4096);
        wr_coef(11, -2000);
        one_pixel(4095, 4095, 4095, r0, r1, r2);
        check("R6 clamp high", r0, 4095);
        check("R6 clamp low from weight", r1, 0);
        check("R6 clamp low from offset", r2, 0);
        set_ctl(1'b1, 0);
        wr_coef(1, 4095);
        wr_coef(3, 4095);
        one_pixel(4095, 4095, 0, r0, r1, r2);
        check("R6 clamp high scale 0", r0, 4095);
    endtask

    task automatic t_unmapped();
        int r0, r1, r2;
        set_ctl(1'b1, 1);
        for (int n = 0; n < 12; n++) wr_coef(n, 0);
        wr_coef(0, 1024);
        wr_coef(5, 2048);
        for (int a = 25; a < 32; a++) wr(a, 8'hFF);
        one_pixel(1000, 300, 0, r0, r1, r2);
        check("R10 ch0 after unmapped writes", r0, model(0, 1000, 300, 0));
        check("R10 ch1 after unmapped writes", r1, model(1, 1000, 300, 0));
        check("R10 enable kept", r2, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_defaults();
        t_modes();
        t_offset();
        t_staging();
        t_saturate();
        t_unmapped();
        set_ctl(1'b0, 1);
        t_bypass();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule